// File: doc/BRIEF.md
# Bus-Synchronized Clock Mode Controller

This block decides how often the bus masters of a small microcontroller may advance. The masters are the CPU, the DMA engine and the data transfer engine. It produces a single clock enable that all of them share. At full speed that enable is high on every cycle. In divided mode it is a one-cycle pulse every 2, 4, 8, 16 or 32 cycles. In sleep it stays low. Peripherals that are not bus masters get their own enable, which stays high in every mode.

Software writes a 3-bit speed code. The new code is latched only when the bus-cycle-end strobe is seen, so a bus access that is in progress always finishes at the rate it started with.

A SLEEP strobe parks the bus masters. It does so only when the standby bit and the low-power bit are both clear. An interrupt wakes the block into whichever rate was in force before sleep.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the mode output is 00 (full speed), `master_en` is high on every cycle and `sleeping` is low.
- R2: A nonzero `speed_sel` written while at full speed changes nothing until a cycle in which `bus_end` is high. After that edge, `mode` reads 01 (divided).
- R3: A `speed_sel` of zero takes effect at the next `bus_end`. After that edge, `mode` reads 00 and `master_en` is high on every cycle.
- R4: In divided mode `master_en` is a one-cycle pulse with period N. N is 2, 4, 8, 16 or 32 for codes 1 to 5, and 32 for codes 6 and 7. The first pulse comes in the cycle right after the switching edge.
- R5: A change between two nonzero codes also waits for `bus_end`. Until then the old pulse period continues unchanged.
- R6: `periph_en` is high in every cycle and every mode.
- R7: A `sleep_req` seen with `stby_bit`=0 and `lowpwr_bit`=0 makes `mode` read 10 and `sleeping` read 1 from the next cycle. `master_en` then stays low.
- R8: A `sleep_req` seen while `stby_bit` or `lowpwr_bit` is 1 has no effect on the mode or on the pulse pattern.
- R9: While asleep, `bus_end` does not load a new code. An `irq` leaves sleep, and the mode and pulse rate that held before sleep return on the next cycle.
- R10: An `irq` outside sleep has no effect on the mode or on the pulse pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_sel | input | 3 | Requested speed code (0 = full speed) |
| bus_end | input | 1 | High in the last cycle of a bus access |
| sleep_req | input | 1 | One-cycle SLEEP instruction strobe |
| stby_bit | input | 1 | Standby select bit; blocks sleep entry when set |
| lowpwr_bit | input | 1 | Low-power select bit; blocks sleep entry when set |
| irq | input | 1 | Interrupt request; wakes from sleep |
| master_en | output | 1 | Clock enable for all bus masters |
| sleeping | output | 1 | High while in sleep |
| periph_en | output | 1 | Clock enable for non-master peripherals |
| mode | output | 2 | 00 full, 01 divided, 10 sleep |

## Verification
The hardest situation to reach from the ports is a sleep period during which a speed write and a `bus_end` both arrive. If the code were loaded there, the block would wake at the wrong rate. The stimulus therefore first settles into the divide-by-4 rate and then enters sleep. During sleep it writes a different code and strobes `bus_end`. It then wakes with `irq` and measures the pulse period, which must still be 4.

A second test holds a pending nonzero code without `bus_end`, to show that the old period persists until the strobe arrives.

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl #(
  parameter int SEL_W   = 3,
  parameter int MAX_LOG = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] speed_sel,
  input  logic             bus_end,
  input  logic             sleep_req,
  input  logic             stby_bit,
  input  logic             lowpwr_bit,
  input  logic             irq,
  output logic             master_en,
  output logic             sleeping,
  output logic             periph_en,
  output logic [1:0]       mode
);
  localparam int CNT_W = MAX_LOG;
  localparam logic [1:0] M_FULL  = 2'b00;
  localparam logic [1:0] M_DIV   = 2'b01;
  localparam logic [1:0] M_SLEEP = 2'b10;

  logic [SEL_W-1:0] cur_code;
  logic             asleep;
  logic [CNT_W-1:0] cnt, cnt_max, cnt_adv;
  logic             sleep_go, wake, apply;

  function automatic logic [CNT_W-1:0] last_count(input logic [SEL_W-1:0] c);
    int sh;
    sh = (int'(c) > MAX_LOG) ? MAX_LOG : int'(c);
    return (sh == 0) ? '0 : CNT_W'((1 << sh) - 1);
  endfunction

  assign cnt_max  = last_count(cur_code);
  assign cnt_adv  = (cnt >= cnt_max) ? '0 : cnt + 1'b1;
  assign sleep_go = !asleep && sleep_req && !stby_bit && !lowpwr_bit;
  assign wake     = asleep && irq;
  assign apply    = !asleep && !sleep_go && bus_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_code <= '0;
      asleep   <= 1'b0;
      cnt      <= '0;
    end else if (sleep_go) begin
      asleep <= 1'b1;
    end else if (wake) begin
      asleep <= 1'b0;
      cnt    <= '0;
    end else if (apply) begin
      cur_code <= speed_sel;
      cnt      <= (speed_sel != cur_code) ? '0 : cnt_adv;
    end else begin
      cnt <= cnt_adv;
    end
  end

  assign mode      = asleep ? M_SLEEP : ((cur_code == '0) ? M_FULL : M_DIV);
  assign master_en = !asleep && ((cur_code == '0) || (cnt == '0));
  assign sleeping  = asleep;
  assign periph_en = 1'b1;

  a_r2_code_on_bus_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_code != $past(cur_code)) |-> $past(bus_end));

  a_r7_sleep_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleeping) |-> $past(sleep_req && !stby_bit && !lowpwr_bit));

  a_r7_no_master_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && $past(sleeping)) |-> !master_en);

  a_r9_wake_restores: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleeping) |-> ($past(irq) && $stable(cur_code) && mode != M_SLEEP));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DIV && $past(mode) == M_DIV && $past(master_en) && $stable(cur_code))
      |-> !master_en);
endmodule

// File: tb/tb_clk_mode_ctrl.sv
`timescale 1ns/1ps
module tb_clk_mode_ctrl;
  logic clk = 0, rst_n = 0;
  logic [2:0] speed_sel = 0;
  logic bus_end = 0, sleep_req = 0, stby_bit = 0, lowpwr_bit = 0, irq = 0;
  logic master_en, sleeping, periph_en;
  logic [1:0] mode;
  int n_chk = 0, n_err = 0;

  clk_mode_ctrl dut (.clk, .rst_n, .speed_sel, .bus_end, .sleep_req, .stby_bit,
                     .lowpwr_bit, .irq, .master_en, .sleeping, .periph_en, .mode);

  always #2 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe_bus_end();
    bus_end = 1; tick(); bus_end = 0;
  endtask

  task automatic expect_pulses(string req, int n, logic [1:0] m);
    for (int k = 0; k < 2 * n; k++) begin
      chk(req, {3'b0, master_en}, {3'b0, (k % n) == 0});
      chk(req, {2'b0, mode}, {2'b0, m});
      chk("R6", {3'b0, periph_en}, 4'h1);
      tick();
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++) begin
      chk("R1 mode", {2'b0, mode}, 4'h0);
      chk("R1 en", {3'b0, master_en}, 4'h1);
      chk("R1 sleeping", {3'b0, sleeping}, 4'h0);
      chk("R6", {3'b0, periph_en}, 4'h1);
      tick();
    end
  endtask

  task automatic t_deferred_entry();
    speed_sel = 3'd2;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R2 hold mode", {2'b0, mode}, 4'h0);
      chk("R2 hold en", {3'b0, master_en}, 4'h1);
    end
    strobe_bus_end();
    expect_pulses("R2/R4 div4", 4, 2'b01);
  endtask

  task automatic t_all_codes();
    for (int c = 1; c < 8; c++) begin
      speed_sel = 3'(c);
      strobe_bus_end();
      expect_pulses("R4 period", (c > 5) ? 32 : (1 << c), 2'b01);
    end
  endtask

  task automatic t_divided_change();
    speed_sel = 3'd3;
    strobe_bus_end();
    speed_sel = 3'd1;
    expect_pulses("R5 old period kept", 8, 2'b01);
    strobe_bus_end();
    expect_pulses("R5 new period", 2, 2'b01);
  endtask

  task automatic t_back_to_full();
    speed_sel = 3'd0;
    tick();
    chk("R3 hold divided", {2'b0, mode}, 4'h1);
    strobe_bus_end();
    for (int k = 0; k < 4; k++) begin
      chk("R3 full mode", {2'b0, mode}, 4'h0);
      chk("R3 full en", {3'b0, master_en}, 4'h1);
      tick();
    end
  endtask

  task automatic t_sleep_divided();
    speed_sel = 3'd2;
    strobe_bus_end();
    expect_pulses("R4 div4", 4, 2'b01);
    stby_bit = 1; sleep_req = 1; tick(); sleep_req = 0; stby_bit = 0;
    chk("R8 stby blocks", {2'b0, mode}, 4'h1);
    chk("R8 stby blocks", {3'b0, sleeping}, 4'h0);
    lowpwr_bit = 1; sleep_req = 1; tick(); sleep_req = 0; lowpwr_bit = 0;
    chk("R8 lowpwr blocks", {2'b0, mode}, 4'h1);
    chk("R8 pattern kept", {3'b0, master_en}, 4'h0);
    tick(); tick();
    chk("R8 pattern kept", {3'b0, master_en}, 4'h1);
    sleep_req = 1; tick(); sleep_req = 0;
    chk("R7 mode", {2'b0, mode}, 4'h2);
    chk("R7 sleeping", {3'b0, sleeping}, 4'h1);
    speed_sel = 3'd5;
    bus_end = 1;
    for (int k = 0; k < 6; k++) begin
      tick();
      chk("R7 en low", {3'b0, master_en}, 4'h0);
      chk("R9 stays asleep", {2'b0, mode}, 4'h2);
      chk("R6", {3'b0, periph_en}, 4'h1);
    end
    bus_end = 0;
    irq = 1; tick(); irq = 0;
    chk("R9 woke", {3'b0, sleeping}, 4'h0);
    expect_pulses("R9 restored div4", 4, 2'b01);
    irq = 1;
    expect_pulses("R10 irq ignored", 4, 2'b01);
    irq = 0;
  endtask

  task automatic t_sleep_full();
    speed_sel = 3'd0;
    strobe_bus_end();
    chk("R3 full", {2'b0, mode}, 4'h0);
    sleep_req = 1; tick(); sleep_req = 0;
    chk("R7 from full", {2'b0, mode}, 4'h2);
    chk("R7 en low", {3'b0, master_en}, 4'h0);
    irq = 1; tick(); irq = 0;
    chk("R9 restored full", {2'b0, mode}, 4'h0);
    chk("R9 restored full", {3'b0, master_en}, 4'h1);
    irq = 1; tick(); irq = 0;
    chk("R10 irq in full", {2'b0, mode}, 4'h0);
  endtask

  initial begin
    #1;
    tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_deferred_entry();
    t_all_codes();
    t_divided_change();
    t_back_to_full();
    t_sleep_divided();
    t_sleep_full();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule